// File: doc/BRIEF.md
# Amplifier Fault Protection Controller

This block guards a class-D power stage. It reads digitized samples of the die temperature, two power-stage rails and one analog rail. Each sample arrives with its own valid strobe. From these it decides whether the output half-bridges may switch. When any rail sags below its threshold, or the die overheats, every half-bridge is asked to go to high impedance and the active-low fault line is pulled low. The thermal trip recovers on its own once the die has cooled well below the trip point. A sagging rail must show a sustained run of good samples before it is trusted again.

The same rail monitors decide power-on readiness. Until every rail has been good, the ready flag stays low and the reset to the external overload latch stays asserted. Two sticky flags record thermal and undervoltage entry events for later inspection. Each is cleared by a one-cycle write-one pulse. The four thresholds are programmable through a simple write port.

Top module: `amp_fault_guard`

## Requirements
- R1: After reset, faultN is 0, hiZ is all ones, porReady is 0, olpReset is 1, and both sticky flags are 0. The thresholds start at these codes: trip 150, recover 120, power rail 760, analog rail 270. Temperature codes are in °C and rail codes are in 10 mV units.
- R2: A temperature sample with its valid strobe high and a code strictly above the trip threshold sets the thermal fault on that clock edge. A code equal to the trip threshold does not set it.
- R3: The thermal fault clears only on a valid sample at or below the recover threshold. Valid samples between the two thresholds leave the fault unchanged.
- R4: Each of the three rails is compared on its own. The two power rails use the power threshold and the analog rail uses the analog threshold. A valid sample strictly below its threshold sets that rail's undervoltage fault on that edge.
- R5: A rail's undervoltage fault clears on the 16th consecutive valid sample at or above its threshold. Any low sample restarts the run. Cycles without a valid strobe neither count toward the run nor break it. Every rail starts in fault after reset.
- R6: faultN is the inverse, and every hiZ bit a copy, of the OR of all fault conditions, delayed by one register. faultN and hiZ always change in the same cycle.
- R7: porReady goes high, and olpReset goes low, one cycle after the last rail fault clears. olpReset is always the inverse of porReady.
- R8: stickyTherm sets when the thermal fault is entered. stickyUv sets when any rail goes from good to faulted. Bit 0 of stsClr clears stickyTherm and bit 1 clears stickyUv. A new entry event in the same cycle as a clear wins.
- R9: A write with cfgWe high loads cfgData into the threshold chosen by cfgAddr: 0 trip, 1 recover, 2 power rail, 3 analog rail. The new value applies from the following cycle.
- R10: A code presented while its valid strobe is low has no effect on any fault or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tempCode | input | 8 | Die temperature sample, °C |
| tempValid | input | 1 | tempCode valid strobe |
| powerRailACode | input | 11 | First power rail sample, 10 mV units |
| powerRailAValid | input | 1 | powerRailACode valid strobe |
| powerRailBCode | input | 11 | Second power rail sample, 10 mV units |
| powerRailBValid | input | 1 | powerRailBCode valid strobe |
| analogRailCode | input | 11 | Analog rail sample, 10 mV units |
| analogRailValid | input | 1 | analogRailCode valid strobe |
| cfgWe | input | 1 | Threshold write enable |
| cfgAddr | input | 2 | Threshold select |
| cfgData | input | 11 | Threshold write data |
| stsClr | input | 2 | Write-one clear pulses for the sticky flags |
| faultN | output | 1 | Active-low fault line |
| hiZ | output | 4 | Per-half-bridge high-impedance request |
| porReady | output | 1 | All rails good |
| olpReset | output | 1 | Reset to the overload-protection latch |
| stickyTherm | output | 1 | Thermal entry seen |
| stickyUv | output | 1 | Undervoltage entry seen |

## Verification
Two functions can land on the same edge: setting a sticky flag from a fresh fault entry, and clearing that flag from a software pulse. The bench drives a trip-level temperature sample together with a stsClr pulse, directed once for the thermal flag, and many times at random for both flags. The flag must read 1 afterwards. A second overlap pairs a threshold write with a sample in the same cycle; that sample must still be judged against the old threshold. A reference model in the bench judges every cycle.

// File: rtl/afg_pkg.sv
package afg_pkg;
  localparam int NUM_RAILS = 3;

  // Per-sample events from the datapath to the control
  typedef struct packed {
    logic                 hot;
    logic                 cool;
    logic [NUM_RAILS-1:0] low;
    logic [NUM_RAILS-1:0] recovered;
  } sampleEv_t;

  // Threshold load strobes from the control to the datapath
  typedef struct packed {
    logic wrTrip;
    logic wrRecover;
    logic wrPower;
    logic wrAnalog;
  } cfgStb_t;
endpackage

// File: rtl/afg_datapath.sv
module afg_datapath
  import afg_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int VOLT_W      = 11,
  parameter int GOOD_RUN    = 16,
  parameter int TRIP_RST    = 150,
  parameter int RECOVER_RST = 120,
  parameter int POWER_RST   = 760,
  parameter int ANALOG_RST  = 270
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [TEMP_W-1:0]                 tempCode,
  input  logic                              tempValid,
  input  logic [NUM_RAILS-1:0][VOLT_W-1:0]  railCode,
  input  logic [NUM_RAILS-1:0]              railValid,
  input  logic [VOLT_W-1:0]                 cfgData,
  input  cfgStb_t                           cfgStb,
  output sampleEv_t                         ev
);
  localparam int CNT_W = $clog2(GOOD_RUN);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GOOD_RUN - 1);

  logic [TEMP_W-1:0] tripThr, recoverThr;
  logic [VOLT_W-1:0] powerThr, analogThr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripThr    <= TEMP_W'(TRIP_RST);
      recoverThr <= TEMP_W'(RECOVER_RST);
      powerThr   <= VOLT_W'(POWER_RST);
      analogThr  <= VOLT_W'(ANALOG_RST);
    end else begin
      if (cfgStb.wrTrip)    tripThr    <= cfgData[TEMP_W-1:0];
      if (cfgStb.wrRecover) recoverThr <= cfgData[TEMP_W-1:0];
      if (cfgStb.wrPower)   powerThr   <= cfgData;
      if (cfgStb.wrAnalog)  analogThr  <= cfgData;
    end
  end

  wire [NUM_RAILS-1:0] lowVec;
  wire [NUM_RAILS-1:0] recVec;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic [CNT_W-1:0] goodCnt;
    wire [VOLT_W-1:0] thr    = (r == NUM_RAILS - 1) ? analogThr : powerThr;
    wire              railOk = railCode[r] >= thr;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        goodCnt <= '0;
      end else if (railValid[r]) begin
        if (!railOk)                goodCnt <= '0;
        else if (goodCnt != CNT_MAX) goodCnt <= goodCnt + CNT_W'(1);
      end
    end

    assign lowVec[r] = railValid[r] && !railOk;
    assign recVec[r] = railValid[r] && railOk && (goodCnt == CNT_MAX);

    // R5: a low sample restarts the good run
    a_r5_low_restarts_run: assert property (@(posedge clk) disable iff (!rstN)
      lowVec[r] |=> (goodCnt == '0));
  end

  assign ev = '{hot:       tempValid && (tempCode > tripThr),
                cool:      tempValid && (tempCode <= recoverThr),
                low:       lowVec,
                recovered: recVec};

  // R10: no event without a strobe
  a_r10_no_event_without_valid: assert property (@(posedge clk) disable iff (!rstN)
    !tempValid |-> !(ev.hot || ev.cool));
endmodule

// File: rtl/afg_control.sv
module afg_control
  import afg_pkg::*;
#(
  parameter int NUM_HB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sampleEv_t         ev,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [1:0]        stsClr,
  output cfgStb_t           cfgStb,
  output logic              faultN,
  output logic [NUM_HB-1:0] hiZ,
  output logic              porReady,
  output logic              olpReset,
  output logic              stickyTherm,
  output logic              stickyUv
);
  logic                 thermFault;
  logic [NUM_RAILS-1:0] uvFault;
  logic                 anyFault;
  logic                 thermEntry, uvEntry;

  assign cfgStb = '{wrTrip:    cfgWe && (cfgAddr == 2'd0),
                    wrRecover: cfgWe && (cfgAddr == 2'd1),
                    wrPower:   cfgWe && (cfgAddr == 2'd2),
                    wrAnalog:  cfgWe && (cfgAddr == 2'd3)};

  assign anyFault   = thermFault || (|uvFault);
  assign thermEntry = ev.hot && !thermFault;
  assign uvEntry    = |(ev.low & ~uvFault);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thermFault <= 1'b0;
      uvFault    <= '1;
    end else begin
      if (ev.hot)       thermFault <= 1'b1;
      else if (ev.cool) thermFault <= 1'b0;
      for (int r = 0; r < NUM_RAILS; r++) begin
        if (ev.low[r])            uvFault[r] <= 1'b1;
        else if (ev.recovered[r]) uvFault[r] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultN      <= 1'b0;
      hiZ         <= '1;
      porReady    <= 1'b0;
      olpReset    <= 1'b1;
      stickyTherm <= 1'b0;
      stickyUv    <= 1'b0;
    end else begin
      faultN      <= !anyFault;
      hiZ         <= {NUM_HB{anyFault}};
      porReady    <= !(|uvFault);
      olpReset    <= |uvFault;
      stickyTherm <= (stickyTherm && !stsClr[0]) || thermEntry;
      stickyUv    <= (stickyUv && !stsClr[1]) || uvEntry;
    end
  end

  // R6: fault line and every Hi-Z request move together
  a_r6_hiz_tracks_fault: assert property (@(posedge clk) disable iff (!rstN)
    hiZ == {NUM_HB{!faultN}});
  // R6: an active condition pulls the fault line one cycle later
  a_r6_fault_delay: assert property (@(posedge clk) disable iff (!rstN)
    anyFault |=> !faultN);
  // R7: the overload reset mirrors readiness
  a_r7_olp_inverse: assert property (@(posedge clk) disable iff (!rstN)
    olpReset == !porReady);
  // R2: a hot sample sets the thermal fault
  a_r2_hot_sets_therm: assert property (@(posedge clk) disable iff (!rstN)
    ev.hot |=> thermFault);
  // R8: an entry event beats a clear pulse
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    thermEntry |=> stickyTherm);

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_chk
    // R5: a rail fault only clears at the end of a full good run
    a_r5_clear_needs_run: assert property (@(posedge clk) disable iff (!rstN)
      $fell(uvFault[r]) |-> $past(ev.recovered[r]));
  end
endmodule

// File: rtl/amp_fault_guard.sv
module amp_fault_guard
  import afg_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int VOLT_W      = 11,
  parameter int NUM_HB      = 4,
  parameter int GOOD_RUN    = 16,
  parameter int TRIP_RST    = 150,
  parameter int RECOVER_RST = 120,
  parameter int POWER_RST   = 760,
  parameter int ANALOG_RST  = 270
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic              tempValid,
  input  logic [VOLT_W-1:0] powerRailACode,
  input  logic              powerRailAValid,
  input  logic [VOLT_W-1:0] powerRailBCode,
  input  logic              powerRailBValid,
  input  logic [VOLT_W-1:0] analogRailCode,
  input  logic              analogRailValid,
  input  logic              cfgWe,
  input  logic [1:0]        cfgAddr,
  input  logic [VOLT_W-1:0] cfgData,
  input  logic [1:0]        stsClr,
  output logic              faultN,
  output logic [NUM_HB-1:0] hiZ,
  output logic              porReady,
  output logic              olpReset,
  output logic              stickyTherm,
  output logic              stickyUv
);
  sampleEv_t ev;
  cfgStb_t   cfgStb;

  logic [NUM_RAILS-1:0][VOLT_W-1:0] railCode;
  logic [NUM_RAILS-1:0]             railValid;

  assign railCode  = {analogRailCode, powerRailBCode, powerRailACode};
  assign railValid = {analogRailValid, powerRailBValid, powerRailAValid};

  afg_datapath #(
    .TEMP_W(TEMP_W), .VOLT_W(VOLT_W), .GOOD_RUN(GOOD_RUN),
    .TRIP_RST(TRIP_RST), .RECOVER_RST(RECOVER_RST),
    .POWER_RST(POWER_RST), .ANALOG_RST(ANALOG_RST)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .tempCode(tempCode), .tempValid(tempValid),
    .railCode(railCode), .railValid(railValid),
    .cfgData(cfgData), .cfgStb(cfgStb), .ev(ev)
  );

  afg_control #(.NUM_HB(NUM_HB)) u_control (
    .clk(clk), .rstN(rstN), .ev(ev),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .stsClr(stsClr),
    .cfgStb(cfgStb), .faultN(faultN), .hiZ(hiZ),
    .porReady(porReady), .olpReset(olpReset),
    .stickyTherm(stickyTherm), .stickyUv(stickyUv)
  );
endmodule

// File: tb/amp_fault_guard_bench.sv
module amp_fault_guard_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0]  tempCode = 8'd25;
  logic        tempValid = 1'b0;
  logic [10:0] railA = 11'd800, railB = 11'd800, railC = 11'd330;
  logic        railAV = 1'b0, railBV = 1'b0, railCV = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = 2'd0;
  logic [10:0] cfgData = '0;
  logic [1:0]  stsClr = 2'b00;
  logic        faultN, porReady, olpReset, stickyTherm, stickyUv;
  logic [3:0]  hiZ;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int  mTrip = 150, mRec = 120, mPow = 760, mAna = 270;
  bit  mTherm = 0;
  bit  mUv [3] = '{1, 1, 1};
  int  mCnt [3] = '{0, 0, 0};
  bit  mFaultN = 0, mReady = 0, mStT = 0, mStU = 0;

  always #4 clk = ~clk;

  amp_fault_guard u_amp_fault_guard (
    .clk(clk), .rstN(rstN), .tempCode(tempCode), .tempValid(tempValid),
    .powerRailACode(railA), .powerRailAValid(railAV),
    .powerRailBCode(railB), .powerRailBValid(railBV),
    .analogRailCode(railC), .analogRailValid(railCV),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .stsClr(stsClr),
    .faultN(faultN), .hiZ(hiZ), .porReady(porReady), .olpReset(olpReset),
    .stickyTherm(stickyTherm), .stickyUv(stickyUv)
  );

  function automatic int railThr(int r);
    return (r == 2) ? mAna : mPow;
  endfunction

  function automatic int railCodeOf(int r);
    return (r == 0) ? int'(railA) : (r == 1) ? int'(railB) : int'(railC);
  endfunction

  function automatic bit railValidOf(int r);
    return (r == 0) ? railAV : (r == 1) ? railBV : railCV;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    bit anyOld = mTherm || mUv[0] || mUv[1] || mUv[2];
    bit uvOld  = mUv[0] || mUv[1] || mUv[2];
    bit hot  = tempValid && (int'(tempCode) > mTrip);
    bit cool = tempValid && (int'(tempCode) <= mRec);
    bit uvEnt = 0;
    bit newUv [3];
    int newCnt [3];
    for (int r = 0; r < 3; r++) begin
      bit v = railValidOf(r);
      bit ok = railCodeOf(r) >= railThr(r);
      newUv[r] = mUv[r];
      newCnt[r] = mCnt[r];
      if (v && !ok) begin
        if (!mUv[r]) uvEnt = 1;
        newUv[r] = 1;
        newCnt[r] = 0;
      end else if (v && ok) begin
        if (mCnt[r] == 15) newUv[r] = 0;
        else newCnt[r] = mCnt[r] + 1;
      end
    end
    mFaultN = !anyOld;
    mReady  = !uvOld;
    mStT = (mStT && !stsClr[0]) || (hot && !mTherm);
    mStU = (mStU && !stsClr[1]) || uvEnt;
    if (hot) mTherm = 1; else if (cool) mTherm = 0;
    for (int r = 0; r < 3; r++) begin
      mUv[r] = newUv[r];
      mCnt[r] = newCnt[r];
    end
    if (cfgWe) begin
      case (cfgAddr)
        2'd0: mTrip = int'(cfgData[7:0]);
        2'd1: mRec  = int'(cfgData[7:0]);
        2'd2: mPow  = int'(cfgData);
        default: mAna = int'(cfgData);
      endcase
    end
  endtask

  // one clock: model update at the edge, compare 2 ns later
  task automatic step();
    @(posedge clk);
    modelEdge();
    #2;
    chk("R6 faultN", faultN, mFaultN);
    chk("R6 hiZ", hiZ, mFaultN ? 0 : 15);
    chk("R7 porReady", porReady, mReady);
    chk("R7 olpReset", olpReset, !mReady);
    chk("R8 stickyTherm", stickyTherm, mStT);
    chk("R8 stickyUv", stickyUv, mStU);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfgWrite(int addr, int data);
    cfgWe = 1; cfgAddr = 2'(addr); cfgData = 11'(data);
    step();
    cfgWe = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset values at the ports
    chk("R1 faultN", faultN, 0);
    chk("R1 hiZ", hiZ, 15);
    chk("R1 porReady", porReady, 0);
    chk("R1 olpReset", olpReset, 1);
    chk("R1 stickyTherm", stickyTherm, 0);
    chk("R1 stickyUv", stickyUv, 0);
    rstN = 1;

    // R5 power-up: 16 good samples clear the rails, ready one cycle later
    railAV = 1; railBV = 1; railCV = 1;
    railA = 11'd760; railB = 11'd800; railC = 11'd270;  // R1 reset thresholds: equal is good
    steps(16);
    chk("R5 porReady before run ends", porReady, 0);
    step();
    chk("R5 porReady after 16 good", porReady, 1);
    chk("R7 olpReset released", olpReset, 0);
    chk("R6 faultN released", faultN, 1);

    // R10: codes without a strobe are ignored
    railAV = 0; railBV = 0; railCV = 0;
    railA = 0; railB = 0; railC = 0;
    tempValid = 0; tempCode = 8'd250;
    steps(4);
    chk("R10 faultN unchanged", faultN, 1);
    chk("R10 porReady unchanged", porReady, 1);
    railA = 11'd800; railB = 11'd800; railC = 11'd330;
    railAV = 1; railBV = 1; railCV = 1;

    // R2: equal to trip is safe, above trips
    tempValid = 1; tempCode = 8'd150;
    steps(2);
    chk("R2 equal trip no fault", faultN, 1);
    tempCode = 8'd151;
    step();
    chk("R8 stickyTherm on entry", stickyTherm, 1);
    chk("R2 faultN one cycle later", faultN, 1);
    step();
    chk("R2 faultN tripped", faultN, 0);
    chk("R6 hiZ all set", hiZ, 15);

    // R3: hysteresis band holds the fault
    tempCode = 8'd130;
    steps(3);
    chk("R3 band holds fault", faultN, 0);
    tempCode = 8'd120;
    step();
    chk("R3 still low on clear edge", faultN, 0);
    step();
    chk("R3 released", faultN, 1);
    chk("R6 hiZ released", hiZ, 0);

    // R8: clear, then clear colliding with a new entry
    stsClr = 2'b01;
    step();
    chk("R8 clear works", stickyTherm, 0);
    tempCode = 8'd200;
    step();
    chk("R8 set wins over clear", stickyTherm, 1);
    stsClr = 2'b00;
    tempCode = 8'd100;
    steps(2);
    stsClr = 2'b01;
    step();
    stsClr = 2'b00;
    chk("R8 clear when idle", stickyTherm, 0);

    // R4: one power rail dips
    railB = 11'd759;
    step();
    chk("R8 stickyUv on entry", stickyUv, 1);
    railB = 11'd760;
    step();
    chk("R4 faultN on rail B", faultN, 0);
    chk("R7 porReady drops", porReady, 0);
    // R5: glitch restarts the run
    steps(9);
    railB = 11'd700;
    step();
    railB = 11'd790;
    steps(16);
    chk("R5 run restarted", faultN, 0);
    step();
    chk("R5 recovered after restart", faultN, 1);

    // R4: analog rail alone
    railC = 11'd269;
    steps(2);
    chk("R4 analog rail fault", faultN, 0);
    railC = 11'd300;
    // R5: gaps without valid neither count nor break
    for (int i = 0; i < 16; i++) begin
      railCV = 1; step();
      railCV = 0; step();
    end
    railCV = 1;
    chk("R5 gaps tolerated", porReady, 1);

    // R9: threshold programming; write in the same cycle as a sample
    tempCode = 8'd110;
    cfgWrite(0, 100);
    chk("R9 old trip applied during write", faultN, 1);
    steps(2);
    chk("R9 new trip applied", faultN, 0);
    cfgWrite(1, 90);
    tempCode = 8'd95;
    steps(2);
    chk("R9 recover not reached", faultN, 0);
    tempCode = 8'd90;
    steps(2);
    chk("R9 new recover applied", faultN, 1);
    cfgWrite(2, 800);
    railA = 11'd790;
    steps(2);
    chk("R9 power threshold raised", faultN, 0);
    cfgWrite(2, 760);
    cfgWrite(3, 270);
    cfgWrite(0, 150);
    cfgWrite(1, 120);
    railA = 11'd800;
    steps(17);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int t = $urandom_range(99);
      tempValid = ($urandom_range(3) != 0);
      tempCode  = 8'($urandom_range(160, 110));
      railAV = ($urandom_range(3) != 0);
      railBV = ($urandom_range(3) != 0);
      railCV = ($urandom_range(3) != 0);
      railA = 11'((t < 3) ? $urandom_range(759, 600) : $urandom_range(900, 760));
      railB = 11'((t > 96) ? $urandom_range(759, 600) : $urandom_range(900, 760));
      railC = 11'((t == 50) ? $urandom_range(269, 200) : $urandom_range(350, 270));
      stsClr = ($urandom_range(19) == 0) ? 2'($urandom_range(3)) : 2'b00;
      step();
    end
    stsClr = 0;

    done = 1;
    summary();
    $finish;
  end

  initial void'($urandom(32'h5eed_0042));
endmodule